// File: doc/BRIEF.md
# Audio Time-Slot Timing Generator

This block turns a reference audio clock into a serial bit clock and groups bit periods into byte-long time slots. It counts those slots inside a programmable super frame and drives a word-select output that marks the frame start. The bit clock comes from one of sixteen division ratios, or from an external bit clock input when the internal divider is not enabled for output. Each bit period begins with a rising bit-clock edge.

The slot counter either runs free or is realigned by the rising edge of an external word-select input that acts as super-frame sync. A control bit decides how that sync is read. It either marks the bit period in which it was high as the first bit of slot 0, or it announces that the next bit period is. A second control bit places the generated word-select on the first bit of slot 0 or one bit period earlier. All logic runs on the reference clock. The external bit clock and sync input pass through synchronizers of the same depth, so they keep their relative alignment.

Top module: `slot_timing_gen`

## Requirements
- R1: `div_sel` values 0 to 15 select the division ratios 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384 and 512, in that order. The internal bit-clock period is that many reference cycles.
- R2: The internal bit clock is high for exactly half of each period, and each period starts with its rising edge.
- R3: With `bclk_oe` high, `bclk` is the internal divider output. With it low, `bclk` follows `ext_bclk` after a two-stage synchronizer, and bit periods start on its rising edges. `bclk_oe_o` is a register copy of `bclk_oe`, one cycle late and 0 in reset.
- R4: A slot lasts 8 bit periods. `eos` is a one-reference-cycle pulse at the close of the eighth bit, so internal-mode pulses are 8×ratio cycles apart.
- R5: `frame_len` holds slots-per-frame minus one, for 1 to 32 slots. `slot_idx` counts 0..`frame_len` and then wraps to 0. With `frame_len`=0 it stays 0.
- R6: With `sync_en` low, `ws_in` has no effect on slot timing.
- R7: With `sync_en` high and `sync_early` low, a rising edge of `ws_in` seen at a bit boundary marks the bit period just ended as bit 0 of slot 0. The next `eos` comes 7 bit periods later.
- R8: With `sync_en` and `sync_early` high, such an edge makes the next bit period bit 0 of slot 0. The next `eos` comes 8 bit periods later.
- R9: With `ws_early` low, `ws_out` is high during the first bit period of slot 0 only.
- R10: With `ws_early` high, `ws_out` is high during the last bit period of slot `frame_len` only.
- R11: Only a low-to-high change of the sampled `ws_in` realigns the counter. Holding it high does not realign again.
- R12: In reset, `slot_idx`=0, `eos`=0 and `bclk_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 4 | Divider stage select |
| bclk_oe | input | 1 | 1: internal divider drives the bit clock; 0: external bit clock used |
| ext_bclk | input | 1 | External bit clock (asynchronous) |
| sync_en | input | 1 | 1: `ws_in` realigns the slot counter |
| sync_early | input | 1 | 1: sync announces the next bit as frame start |
| ws_early | input | 1 | 1: `ws_out` leads slot 0 by one bit period |
| frame_len | input | 5 | Slots per super frame minus one |
| ws_in | input | 1 | External word-select / super-frame sync |
| bclk | output | 1 | Bit clock in use |
| bclk_oe_o | output | 1 | Registered bit-clock output enable |
| slot_idx | output | 5 | Current slot number |
| eos | output | 1 | End-of-slot strobe |
| ws_out | output | 1 | Generated word-select |

## Verification
The bench drives the external bit clock itself, so it knows each bit boundary. It then checks in which bit period the first end-of-slot appears after a sync pulse. A design that confuses the two sync alignments lands that strobe one period early or late. A design that realigns on the level instead of the edge loses every strobe while the sync is held high. A design that does not gate the sync with its enable shifts strobes that should stay on their free-running grid. The bench also measures the period and high time for the shortest ratio, for ratio 8 and for ratio 384, where a wrong table entry or an off-by-one terminal count changes the counted cycles. It also checks the slot wrap at a four-slot frame and at a one-slot frame, and the word-select position in both output modes.

// File: rtl/slot_timing_pkg.sv
package slot_timing_pkg;
  localparam int DIV_W    = 10;  // widest ratio is 512
  localparam int SEL_W    = 4;   // sixteen stages
  localparam int SLOT_W   = 5;   // up to 32 slots
  localparam int BIT_W    = 3;   // 8 bits per slot
  localparam int N_STAGES = 1 << SEL_W;

  // ratio table: interleaved powers of two and 1.5x powers of two
  function automatic logic [DIV_W-1:0] ratio_of(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] r;
    case (sel)
      4'd0:  r = 10'd2;
      4'd1:  r = 10'd4;
      4'd2:  r = 10'd6;
      4'd3:  r = 10'd8;
      4'd4:  r = 10'd12;
      4'd5:  r = 10'd16;
      4'd6:  r = 10'd24;
      4'd7:  r = 10'd32;
      4'd8:  r = 10'd48;
      4'd9:  r = 10'd64;
      4'd10: r = 10'd96;
      4'd11: r = 10'd128;
      4'd12: r = 10'd192;
      4'd13: r = 10'd256;
      4'd14: r = 10'd384;
      default: r = 10'd512;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bclk_divider.sv
module bclk_divider
  import slot_timing_pkg::*;
#(
  parameter int CNT_W  = DIV_W,
  parameter int DSEL_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DSEL_W-1:0] div_sel,
  output logic              bclk_int,
  output logic              tick_int
);
  logic [CNT_W-1:0] ratio, half, last, cnt;

  assign ratio = CNT_W'(ratio_of(SEL_W'(div_sel)));
  assign half  = ratio >> 1;
  assign last  = ratio - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else                  cnt <= cnt + CNT_W'(1);
  end

  // high for the first half of each period, tick on its final cycle
  assign bclk_int = (cnt < half);
  assign tick_int = (cnt >= last);

  // R2
  int_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_int |=> !tick_int)
    else $error("divider tick lasted more than one cycle");

  // R2
  int_rise_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_int |=> bclk_int)
    else $error("bit period did not start high");
endmodule

// File: rtl/bit_source.sv
module bit_source #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_int,
  input  logic bclk_int,
  input  logic tick_int,
  input  logic ext_bclk,
  input  logic ws_in,
  output logic bclk,
  output logic bit_tick,
  output logic ws_s,
  output logic oe_q
);
  logic ext_s, ext_d, ext_tick;

  // same depth for clock and sync keeps them aligned
  generate
    if (SYNC_STAGES == 1) begin : g_one
      logic ext_r, ws_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ext_r <= 1'b0;
          ws_r  <= 1'b0;
        end else begin
          ext_r <= ext_bclk;
          ws_r  <= ws_in;
        end
      end
      assign ext_s = ext_r;
      assign ws_s  = ws_r;
    end else begin : g_many
      logic [SYNC_STAGES-1:0] ext_sh, ws_sh;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ext_sh <= '0;
          ws_sh  <= '0;
        end else begin
          ext_sh <= {ext_sh[SYNC_STAGES-2:0], ext_bclk};
          ws_sh  <= {ws_sh[SYNC_STAGES-2:0], ws_in};
        end
      end
      assign ext_s = ext_sh[SYNC_STAGES-1];
      assign ws_s  = ws_sh[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_d <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      ext_d <= ext_s;
      oe_q  <= use_int;
    end
  end

  assign ext_tick = ext_s & ~ext_d;
  assign bclk     = use_int ? bclk_int : ext_s;
  assign bit_tick = use_int ? tick_int : ext_tick;

  // R3
  ext_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick)
    else $error("external edge gave a long tick");
endmodule

// File: rtl/slot_counter.sv
module slot_counter
  import slot_timing_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int BW = BIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          ws_s,
  input  logic          sync_en,
  input  logic          sync_early,
  input  logic [SW-1:0] frame_len,
  output logic [BW-1:0] bit_idx,
  output logic [SW-1:0] slot_idx,
  output logic          eos
);
  localparam logic [BW-1:0] LAST_BIT = {BW{1'b1}};

  logic ws_prev, resync;

  always_ff @(posedge clk) begin
    if (!rst_n)        ws_prev <= 1'b0;
    else if (bit_tick) ws_prev <= ws_s;
  end

  assign resync = bit_tick & sync_en & ws_s & ~ws_prev;
  assign eos    = bit_tick & (bit_idx == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (resync) begin
      bit_idx  <= sync_early ? BW'(0) : BW'(1);
      slot_idx <= '0;
    end else if (bit_tick) begin
      bit_idx <= bit_idx + BW'(1);
      if (bit_idx == LAST_BIT)
        slot_idx <= (slot_idx >= frame_len) ? SW'(0) : slot_idx + SW'(1);
    end
  end

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !resync && slot_idx < frame_len) |=> slot_idx == $past(slot_idx) + SW'(1))
    else $error("slot did not advance");

  // R5
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !resync && slot_idx >= frame_len) |=> slot_idx == '0)
    else $error("slot did not wrap");

  // R7
  resync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (slot_idx == '0) && (bit_idx == ($past(sync_early) ? BW'(0) : BW'(1))))
    else $error("sync gave wrong alignment");

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(bit_idx) && $stable(slot_idx))
    else $error("counter moved without a bit tick");

  // R4
  eos_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> !eos)
    else $error("end-of-slot longer than one cycle");
endmodule

// File: rtl/ws_gen.sv
module ws_gen
  import slot_timing_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int BW = BIT_W
) (
  input  logic [BW-1:0] bit_idx,
  input  logic [SW-1:0] slot_idx,
  input  logic [SW-1:0] frame_len,
  input  logic          ws_early,
  output logic          ws_out
);
  localparam logic [BW-1:0] LAST_BIT = {BW{1'b1}};

  always_comb begin
    if (ws_early) ws_out = (slot_idx == frame_len) && (bit_idx == LAST_BIT);
    else          ws_out = (slot_idx == '0) && (bit_idx == '0);
  end
endmodule

// File: rtl/slot_timing_gen.sv
module slot_timing_gen
  import slot_timing_pkg::*;
#(
  parameter int CNT_W       = DIV_W,
  parameter int DSEL_W      = SEL_W,
  parameter int SW          = SLOT_W,
  parameter int BW          = BIT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DSEL_W-1:0] div_sel,
  input  logic              bclk_oe,
  input  logic              ext_bclk,
  input  logic              sync_en,
  input  logic              sync_early,
  input  logic              ws_early,
  input  logic [SW-1:0]     frame_len,
  input  logic              ws_in,
  output logic              bclk,
  output logic              bclk_oe_o,
  output logic [SW-1:0]     slot_idx,
  output logic              eos,
  output logic              ws_out
);
  logic          bclk_int, tick_int, bit_tick, ws_s;
  logic [BW-1:0] bit_idx;

  bclk_divider #(.CNT_W(CNT_W), .DSEL_W(DSEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
    .bclk_int(bclk_int), .tick_int(tick_int)
  );

  bit_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .use_int(bclk_oe),
    .bclk_int(bclk_int), .tick_int(tick_int),
    .ext_bclk(ext_bclk), .ws_in(ws_in),
    .bclk(bclk), .bit_tick(bit_tick), .ws_s(ws_s), .oe_q(bclk_oe_o)
  );

  slot_counter #(.SW(SW), .BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ws_s(ws_s),
    .sync_en(sync_en), .sync_early(sync_early), .frame_len(frame_len),
    .bit_idx(bit_idx), .slot_idx(slot_idx), .eos(eos)
  );

  ws_gen #(.SW(SW), .BW(BW)) u_ws (
    .bit_idx(bit_idx), .slot_idx(slot_idx), .frame_len(frame_len),
    .ws_early(ws_early), .ws_out(ws_out)
  );
endmodule

// File: tb/test_slot_timing_gen.sv
module test_slot_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_sel = 4'd0;
  logic       bclk_oe = 1'b1, ext_bclk = 1'b0;
  logic       sync_en = 1'b0, sync_early = 1'b0, ws_early = 1'b0;
  logic [4:0] frame_len = 5'd0;
  logic       ws_in = 1'b0;
  logic       bclk, bclk_oe_o, eos, ws_out;
  logic [4:0] slot_idx;

  int n_checks = 0, n_fail = 0;
  bit eos_arr[64];
  bit ws_arr[64];
  int slot_arr[64];

  always #10 clk = ~clk;

  slot_timing_gen i_slot_timing_gen (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .bclk_oe(bclk_oe),
    .ext_bclk(ext_bclk), .sync_en(sync_en), .sync_early(sync_early),
    .ws_early(ws_early), .frame_len(frame_len), .ws_in(ws_in),
    .bclk(bclk), .bclk_oe_o(bclk_oe_o), .slot_idx(slot_idx),
    .eos(eos), .ws_out(ws_out)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    ws_in = 1'b0; ext_bclk = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rise();
    logic p;
    p = bclk;
    forever begin
      @(negedge clk);
      if (!p && bclk) break;
      p = bclk;
    end
  endtask

  task automatic t_reset();
    bclk_oe = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", "slot_idx in reset", slot_idx, 0);
    check("R12", "eos in reset", eos, 0);
    check("R12", "bclk_oe_o in reset", bclk_oe_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", "bclk_oe_o after one cycle", bclk_oe_o, 1);
  endtask

  task automatic t_ratio(logic [3:0] sel, int ratio);
    int per, hi;
    logic p;
    div_sel = sel;
    wait_rise(); wait_rise();
    per = 1; hi = 1; p = bclk;
    forever begin
      @(negedge clk);
      if (!p && bclk) break;
      per++;
      if (bclk) hi++;
      p = bclk;
    end
    check("R1", $sformatf("period sel %0d", sel), per, ratio);
    check("R2", $sformatf("high time sel %0d", sel), hi, ratio / 2);
  endtask

  task automatic t_eos_spacing();
    int gap;
    div_sel = 4'd1;
    do_reset();
    while (!eos) @(negedge clk);
    @(negedge clk);
    check("R4", "eos width", eos, 0);
    gap = 1;
    while (!eos) begin @(negedge clk); gap++; end
    check("R4", "eos spacing ratio 4", gap, 32);
  endtask

  task automatic t_free_wrap();
    int hi_cnt, bad;
    div_sel = 4'd0; frame_len = 5'd3; ws_early = 1'b0; sync_en = 1'b0;
    do_reset();
    for (int i = 0; i < 6; i++) begin
      while (!eos) @(negedge clk);
      check("R5", $sformatf("slot at eos %0d", i), slot_idx, i % 4);
      @(negedge clk);
    end
    hi_cnt = 0; bad = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (ws_out) begin hi_cnt++; if (slot_idx != 0) bad++; end
    end
    check("R9", "ws_out cycles per frame", hi_cnt, 2);
    check("R9", "ws_out outside slot 0", bad, 0);
    frame_len = 5'd0;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      while (!eos) @(negedge clk);
      check("R5", "one-slot frame stays at 0", slot_idx, 0);
      @(negedge clk);
    end
  endtask

  // one external bit period = 8 reference cycles; ws_in changes mid-period
  task automatic run_ext(int nper, int k, int len);
    int bhi, blo;
    bhi = 0; blo = 0;
    for (int j = 0; j < nper; j++) begin
      eos_arr[j] = 1'b0;
      ext_bclk = 1'b1;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (eos) eos_arr[j] = 1'b1;
      end
      if (bclk) bhi++;
      ext_bclk = 1'b0;
      if (j == k) ws_in = 1'b1;
      if (j == k + len) ws_in = 1'b0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (eos) eos_arr[j] = 1'b1;
      end
      if (!bclk) blo++;
      ws_arr[j] = ws_out;
      slot_arr[j] = slot_idx;
    end
    ws_in = 1'b0;
    check("R3", "bclk follows ext high", bhi, nper);
    check("R3", "bclk follows ext low", blo, nper);
  endtask

  task automatic t_no_sync();
    int e0, cnt;
    bclk_oe = 1'b0; sync_en = 1'b0; frame_len = 5'd1;
    do_reset();
    run_ext(40, 12, 1);
    e0 = -1;
    for (int j = 0; j < 40; j++) if (eos_arr[j] && e0 < 0) e0 = j;
    cnt = 0;
    for (int j = 0; j < 40; j++) if (eos_arr[j]) cnt++;
    check("R6", "eos grid kept at +8", eos_arr[e0 + 8], 1);
    check("R6", "eos grid kept at +24", eos_arr[e0 + 24], 1);
    check("R6", "eos count unchanged", cnt, (39 - e0) / 8 + 1);
  endtask

  task automatic t_sync_insync();
    int early;
    bclk_oe = 1'b0; sync_en = 1'b1; sync_early = 1'b0; ws_early = 1'b0;
    frame_len = 5'd1;
    do_reset();
    run_ext(40, 10, 1);
    early = 0;
    for (int j = 11; j < 18; j++) if (eos_arr[j]) early++;
    check("R7", "no eos before realigned slot end", early, 0);
    check("R7", "eos 8 periods after sync bit", eos_arr[18], 1);
    check("R7", "slot after first eos", slot_arr[18], 1);
    check("R9", "ws_out on slot0 bit0", ws_arr[26], 1);
    check("R9", "ws_out low before", ws_arr[25], 0);
    check("R9", "ws_out low after", ws_arr[27], 0);
  endtask

  task automatic t_sync_early();
    bclk_oe = 1'b0; sync_en = 1'b1; sync_early = 1'b1; ws_early = 1'b1;
    frame_len = 5'd1;
    do_reset();
    run_ext(40, 10, 1);
    check("R8", "no eos one period too soon", eos_arr[18], 0);
    check("R8", "eos 9 periods after sync bit", eos_arr[19], 1);
    check("R10", "ws_out on last bit of last slot", ws_arr[26], 1);
    check("R10", "ws_out low before", ws_arr[25], 0);
    check("R10", "ws_out low after", ws_arr[27], 0);
  endtask

  task automatic t_held_sync();
    int mid;
    bclk_oe = 1'b0; sync_en = 1'b1; sync_early = 1'b0; ws_early = 1'b0;
    frame_len = 5'd1;
    do_reset();
    run_ext(48, 10, 30);
    mid = 0;
    for (int j = 19; j < 26; j++) if (eos_arr[j]) mid++;
    check("R11", "eos at first slot end", eos_arr[18], 1);
    check("R11", "no realign while held", mid, 0);
    check("R11", "eos grid while held +16", eos_arr[26], 1);
    check("R11", "eos grid while held +24", eos_arr[34], 1);
  endtask

  initial begin
    #(20 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(4'd0, 2);
    t_ratio(4'd3, 8);
    t_ratio(4'd14, 384);
    t_eos_spacing();
    t_free_wrap();
    t_no_sync();
    t_sync_insync();
    t_sync_early();
    t_held_sync();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule